// File: doc/BRIEF.md
# Successive-Approximation Sequencer with Power Control

This block runs the eight-step binary search of a successive-approximation converter and decides when the converter is powered. A convert-start pulse, raised once a serial control word has been taken in, captures the clock mode, the keep-powered bit and the output format. The block then presents a trial code to the capacitive DAC and reads the comparator back one bit at a time, most significant bit first. In external mode a decision is taken on each falling edge of the serial clock, which arrives as a one-cycle pulse synchronised to the system clock. In internal mode a decision is taken on each tick of an internal divider, and the strobe stays low until the search ends.

When the search ends, the code is stored as straight binary for unipolar inputs or as two's complement for bipolar inputs, and a done flag is raised. If the keep-powered bit was clear, the converter powers down after that one conversion and wakes again on the next start. A three-level shutdown input is decoded from three flags. When it is low, the converter is forced off at once and any search in progress is dropped. When it is high, the converter stays on but the reference is disabled. When it floats, both are on. An abort from the serial slave empties the search register and clears the done flag.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the trial code is 0, the result code is 0 (zeros are shifted out until a conversion occurs), done and busy are 0, the strobe is 1, the mode is internal, and with the shutdown input floating both power and reference enables are 1.
- R2: The cycle after start is captured, the trial code is 0x80. At each decision the current trial bit keeps the comparator value (1 = input at or above the trial) and the next lower bit is set. The final code equals the input level.
- R3: In external mode (mode bit 1) exactly one decision is taken per serial-clock fall pulse. Done is 0 after the seventh pulse and 1 the cycle after the eighth, and no decision is taken without pulses.
- R4: In internal mode (mode bit 0) one decision is taken every ICLK_DIV system cycles. Done rises exactly 8*ICLK_DIV cycles after the capturing edge, serial-clock pulses are ignored, and the strobe is 0 during the search and 1 at its end.
- R5: The clock mode is latched only at start. Changing the mode input during a search has no effect on it.
- R6: With the format bit at 0 (unipolar) the result is the raw search code. With it at 1 (bipolar) the result is the raw code with bit 7 inverted, which gives two's complement.
- R7: In unipolar mode, a negative differential input holds the comparator at 0 for every step, and the result is code 0.
- R8: With the keep-powered bit at 0, power stays on during the search and drops the cycle after it ends. The next start restores power. With the bit at 1, power stays on.
- R9: With the shutdown input low, the next cycle shows busy 0, done 0 and strobe 1. Power and reference enables are 0, and start is ignored while the input stays low.
- R10: With the shutdown input high, power is 1 and reference is 0. With it floating, both are 1.
- R11: Abort clears the trial code, busy and done on the next cycle and leaves the power state unchanged.
- R12: A start during a search restarts it: the trial returns to 0x80 and the newly captured mode is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | One-cycle pulse that starts a conversion |
| mode_ext | input | 1 | Clock mode captured at start: 1 external, 0 internal |
| keep_on | input | 1 | Keep-powered bit captured at start |
| bipolar | input | 1 | Output format captured at start: 1 two's complement |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above the trial |
| sclk_fall | input | 1 | One-cycle pulse per serial-clock falling edge |
| abort | input | 1 | Drop the search and clear done |
| shdn_lo | input | 1 | Shutdown input decoded low |
| shdn_fl | input | 1 | Shutdown input decoded floating |
| shdn_hi | input | 1 | Shutdown input decoded high |
| dac_trial | output | 8 | Trial code presented to the DAC |
| code | output | 8 | Formatted result of the last finished search |
| done | output | 1 | Result valid |
| busy | output | 1 | Search in progress |
| strb | output | 1 | Internal-mode strobe, low while converting |
| pwr_on | output | 1 | Converter power enable |
| ref_on | output | 1 | Reference enable |

## Verification
The assertions assume that at most one shutdown flag is high at a time, that the serial-clock fall and start inputs are single-cycle pulses, and that the comparator reflects the trial code presented in the same cycle. The bench models the comparator combinationally from a held input level and the registered trial code. Its shutdown task always drives one flag, and every pulse it issues lasts exactly one cycle between two falling edges of the system clock. Random trials vary level, mode, format and keep-powered bit within these rules, and directed cases cover the extremes 0x00 and 0xFF, a negative unipolar input, and restarts and kills during a search.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        SD_FLOAT = 2'd0,
        SD_HIGH  = 2'd1,
        SD_LOW   = 2'd2
    } sd_level_e;

    typedef enum logic {
        CLK_INT = 1'b0,
        CLK_EXT = 1'b1
    } clk_mode_e;

endpackage

// File: rtl/sar_shdn_decode.sv
module sar_shdn_decode
    import sar_seq_pkg::*;
(
    input  logic      lo,
    input  logic      fl,
    input  logic      hi,
    output sd_level_e level
);
    // Low wins over high; anything else counts as floating.
    always_comb begin
        if (lo)
            level = SD_LOW;
        else if (hi && !fl)
            level = SD_HIGH;
        else
            level = SD_FLOAT;
    end
endmodule

// File: rtl/sar_iclk_div.sv
module sar_iclk_div #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign tick = run && !clr && (cnt_q == LAST);

    always_comb begin
        if (clr || !run)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R4: ticks of the divider are never back to back when DIV > 1
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/sar_step_core.sv
module sar_step_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clear,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] trial,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] fin_code
);
    localparam int IW = (W > 2) ? $clog2(W) : 1;
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [W-1:0]  sar;
    } core_t;

    core_t s_q, s_d;
    logic  take;

    assign take = s_q.busy && step && !load && !clear;

    always_comb begin
        s_d = s_q;
        fin = 1'b0;
        if (clear) begin
            s_d.busy = 1'b0;
            s_d.idx  = '0;
            s_d.sar  = '0;
        end else if (load) begin
            s_d.busy = 1'b1;
            s_d.idx  = IW'(W - 1);
            s_d.sar  = MSB_ONLY;
        end else if (take) begin
            s_d.sar[s_q.idx] = cmp;
            if (s_q.idx == '0) begin
                s_d.busy = 1'b0;
                fin      = 1'b1;
            end else begin
                s_d.sar[s_q.idx - 1'b1] = 1'b1;
                s_d.idx = s_q.idx - 1'b1;
            end
        end
        fin_code = s_d.sar;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign trial = s_q.sar;
    assign busy  = s_q.busy;

    // R2 / R12: a load always presents the MSB-only trial next
    a_r2_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (trial == MSB_ONLY && busy));
    // R11: clearing empties the register
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (trial == '0 && !busy));
    // R2: without a step the trial does not move
    a_r2_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step && !load && !clear) |=> $stable(trial));
endmodule

// File: rtl/sar_pwr_ctl.sv
module sar_pwr_ctl
    import sar_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sd_level_e level,
    input  logic      wake,
    input  logic      sleep,
    output logic      pwr_on,
    output logic      ref_on
);
    typedef struct packed {
        logic soft_off;
    } pwr_t;

    pwr_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (level == SD_LOW)
            p_d.soft_off = 1'b0;
        else if (wake)
            p_d.soft_off = 1'b0;
        else if (sleep)
            p_d.soft_off = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            p_q <= '0;
        else
            p_q <= p_d;
    end

    assign pwr_on = (level != SD_LOW) && !p_q.soft_off;
    assign ref_on = pwr_on && (level != SD_HIGH);

    // R8: a wake leaves the converter powered unless the pin is low
    a_r8_wake_powers: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (pwr_on || level == SD_LOW));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int W        = 8,
    parameter int ICLK_DIV = 250
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start,
    input  logic         mode_ext,
    input  logic         keep_on,
    input  logic         bipolar,
    input  logic         cmp_hi,
    input  logic         sclk_fall,
    input  logic         abort,
    input  logic         shdn_lo,
    input  logic         shdn_fl,
    input  logic         shdn_hi,
    output logic [W-1:0] dac_trial,
    output logic [W-1:0] code,
    output logic         done,
    output logic         busy,
    output logic         strb,
    output logic         pwr_on,
    output logic         ref_on
);
    typedef struct packed {
        clk_mode_e    mode;
        logic         keep;
        logic         bip;
        logic         done;
        logic [W-1:0] result;
    } ctl_t;

    ctl_t       c_q, c_d;
    sd_level_e  level;
    logic       kill, go, clr, step, tick, fin;
    logic [W-1:0] fin_code;

    sar_shdn_decode u_dec (
        .lo    (shdn_lo),
        .fl    (shdn_fl),
        .hi    (shdn_hi),
        .level (level)
    );

    assign kill = (level == SD_LOW);
    assign go   = conv_start && !kill && !abort;
    assign clr  = kill || abort;

    sar_iclk_div #(.DIV(ICLK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go || clr),
        .run   (busy && c_q.mode == CLK_INT),
        .tick  (tick)
    );

    assign step = busy && ((c_q.mode == CLK_EXT) ? sclk_fall : tick);

    sar_step_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .clear    (clr),
        .step     (step),
        .cmp      (cmp_hi),
        .trial    (dac_trial),
        .busy     (busy),
        .fin      (fin),
        .fin_code (fin_code)
    );

    sar_pwr_ctl u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (level),
        .wake   (go),
        .sleep  (fin && !c_q.keep),
        .pwr_on (pwr_on),
        .ref_on (ref_on)
    );

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.done = 1'b0;
        end else if (go) begin
            c_d.mode = mode_ext ? CLK_EXT : CLK_INT;
            c_d.keep = keep_on;
            c_d.bip  = bipolar;
            c_d.done = 1'b0;
        end else if (fin) begin
            c_d.done   = 1'b1;
            c_d.result = c_q.bip ? {~fin_code[W-1], fin_code[W-2:0]} : fin_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= '{mode: CLK_INT, keep: 1'b0, bip: 1'b0, done: 1'b0, result: '0};
        else
            c_q <= c_d;
    end

    assign code = c_q.result;
    assign done = c_q.done;
    assign strb = !(busy && c_q.mode == CLK_INT);

    // R9: a low shutdown level stops everything on the next cycle
    a_r9_shdn_stops: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!busy && !done));
    // R4: an internal-mode start pulls the strobe low
    a_r4_strobe_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !mode_ext) |=> !strb);
    // R8: finishing without keep-powered drops power
    a_r8_sleep_after: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !c_q.keep) |=> !pwr_on);
    // R3: done only rises out of a running search
    a_r3_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    // R5: the latched mode only moves on a start
    a_r5_mode_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(c_q.mode));
endmodule

// File: tb/sar_seq_top_test.sv
module sar_seq_top_test;
    localparam int DIV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 0, mode_ext = 0, keep_on = 1, bipolar = 0;
    logic sclk_fall = 0, abort = 0;
    logic shdn_lo = 0, shdn_fl = 1, shdn_hi = 0;
    logic cmp_hi;
    logic [7:0] dac_trial, code;
    logic done, busy, strb, pwr_on, ref_on;
    logic [7:0] vin = 0;
    logic neg = 0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign cmp_hi = neg ? 1'b0 : (vin >= dac_trial);

    sar_seq_top #(.W(8), .ICLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .mode_ext(mode_ext),
        .keep_on(keep_on), .bipolar(bipolar), .cmp_hi(cmp_hi), .sclk_fall(sclk_fall),
        .abort(abort), .shdn_lo(shdn_lo), .shdn_fl(shdn_fl), .shdn_hi(shdn_hi),
        .dac_trial(dac_trial), .code(code), .done(done), .busy(busy), .strb(strb),
        .pwr_on(pwr_on), .ref_on(ref_on)
    );

    function automatic logic [7:0] exp_code(logic [7:0] v, logic n, logic b);
        if (n && !b) return 8'h00;
        return b ? (v ^ 8'h80) : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input logic ext, input logic keep, input logic bip);
        @(negedge clk);
        conv_start = 1; mode_ext = ext; keep_on = keep; bipolar = bip;
        @(negedge clk);
        conv_start = 0;
    endtask

    task automatic pulse_sclk();
        sclk_fall = 1;
        @(negedge clk);
        sclk_fall = 0;
        @(negedge clk);
    endtask

    task automatic set_shdn(input int lvl); // 0 float, 1 high, 2 low
        shdn_fl = (lvl == 0); shdn_hi = (lvl == 1); shdn_lo = (lvl == 2);
    endtask

    task automatic run_int(input logic [7:0] v, input logic n, input logic bip,
                           input logic keep, input bit sclk_noise);
        vin = v; neg = n;
        do_start(1'b0, keep, bip);
        chk(dac_trial == 8'h80, "R2 first trial", dac_trial, 8'h80);
        chk(strb == 1'b0, "R4 strobe low", strb, 0);
        for (int i = 0; i < 8*DIV - 1; i++) begin
            sclk_fall = sclk_noise;
            @(negedge clk);
        end
        sclk_fall = 0;
        chk(done == 1'b0, "R4 not done early", done, 0);
        wait_n(1);
        chk(done == 1'b1, "R4 done on time", done, 1);
        chk(strb == 1'b1, "R4 strobe high at end", strb, 1);
        chk(code == exp_code(v, n, bip), "R6 result", code, exp_code(v, n, bip));
        chk(pwr_on == keep, "R8 power after", pwr_on, keep);
    endtask

    task automatic run_ext(input logic [7:0] v, input logic n, input logic bip,
                           input logic keep);
        vin = v; neg = n;
        do_start(1'b1, keep, bip);
        chk(pwr_on == 1'b1, "R8 power during", pwr_on, 1);
        for (int i = 0; i < 7; i++) pulse_sclk();
        chk(done == 1'b0, "R3 not done after 7", done, 0);
        sclk_fall = 1;
        @(negedge clk);
        sclk_fall = 0;
        chk(done == 1'b1, "R3 done after 8", done, 1);
        chk(code == exp_code(v, n, bip), "R2 R6 ext result", code, exp_code(v, n, bip));
        chk(pwr_on == keep, "R8 power after ext", pwr_on, keep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        wait_n(3);
        rst_n = 1;
        wait_n(1);
        // R1 reset state
        chk(dac_trial == 0, "R1 trial", dac_trial, 0);
        chk(code == 0, "R1 code", code, 0);
        chk(!done && !busy, "R1 done busy", {done, busy}, 0);
        chk(strb == 1, "R1 strobe", strb, 1);
        chk(pwr_on && ref_on, "R1 power ref", {pwr_on, ref_on}, 3);

        // R2 R4 internal, serial pulses ignored
        run_int(8'hA5, 0, 0, 1, 1);
        run_int(8'hFF, 0, 0, 1, 0);
        run_int(8'h00, 0, 0, 1, 0);

        // R3 R5 external, no progress without pulses, mode change ignored
        vin = 8'h3C; neg = 0;
        do_start(1'b1, 1'b0, 1'b1);
        mode_ext = 0;
        wait_n(8*DIV + 3);
        chk(busy == 1 && done == 0, "R3 R5 waits for pulses", {busy, done}, 2);
        for (int i = 0; i < 8; i++) pulse_sclk();
        chk(done == 1, "R5 completes on pulses", done, 1);
        chk(code == 8'hBC, "R6 bipolar code", code, 8'hBC);
        chk(pwr_on == 0, "R8 powered down", pwr_on, 0);
        do_start(1'b1, 1'b1, 1'b0);
        chk(pwr_on == 1, "R8 start wakes", pwr_on, 1);
        abort = 1; wait_n(1); abort = 0;

        // R7 negative unipolar
        run_ext(8'h77, 1, 0, 1);
        run_int(8'h90, 1, 0, 1, 0);

        // R9 shutdown mid conversion
        vin = 8'h55; neg = 0;
        do_start(1'b0, 1'b1, 1'b0);
        wait_n(10);
        set_shdn(2);
        wait_n(1);
        chk(!busy && !done && strb, "R9 stopped", {busy, done, strb}, 1);
        chk(!pwr_on && !ref_on, "R9 off", {pwr_on, ref_on}, 0);
        do_start(1'b0, 1'b1, 1'b0);
        wait_n(1);
        chk(busy == 0, "R9 start ignored", busy, 0);
        // R10 levels
        set_shdn(1);
        wait_n(1);
        chk(pwr_on && !ref_on, "R10 high level", {pwr_on, ref_on}, 2);
        set_shdn(0);
        wait_n(1);
        chk(pwr_on && ref_on, "R10 float level", {pwr_on, ref_on}, 3);

        // R11 abort mid search and after done
        do_start(1'b0, 1'b1, 1'b0);
        wait_n(12);
        abort = 1; wait_n(1); abort = 0;
        chk(dac_trial == 0 && !busy && !done, "R11 abort clears", {dac_trial, busy, done}, 0);
        chk(pwr_on == 1, "R11 power kept", pwr_on, 1);
        run_ext(8'h12, 0, 0, 1);
        abort = 1; wait_n(1); abort = 0;
        chk(done == 0, "R11 done cleared", done, 0);

        // R12 restart with new mode
        vin = 8'hC3;
        do_start(1'b1, 1'b1, 1'b0);
        pulse_sclk(); pulse_sclk(); pulse_sclk();
        run_int(8'hC3, 0, 0, 1, 1);
        chk(code == 8'hC3, "R12 restart result", code, 8'hC3);

        // random mix
        for (int k = 0; k < 30; k++) begin
            logic [7:0] v;
            logic b, e, kp, n;
            v  = 8'($urandom);
            b  = 1'($urandom);
            e  = 1'($urandom);
            kp = 1'($urandom);
            n  = b ? 1'b0 : (($urandom % 5) == 0);
            if (e) run_ext(v, n, b, kp);
            else   run_int(v, n, b, kp, 1'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule